// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

The controller gathers level-sensitive interrupt requests from up to 32 on-chip peripheral channels and drives one request line to the processor. Software controls it through a small synchronous register port.

The port has four word addresses:
- 0: configuration.
- 1: enable mask.
- 2: in-service set.
- 3: vector.

Among sources that are requesting, enabled and not already in service, a priority picker chooses a winner. By default the highest vector number wins. A promote field in the configuration can place one chosen source above all others. The processor line is raised only when the global enable is set and the winner ranks above every source currently in service.

To take an interrupt, software writes a 1 to the acknowledge bit of the vector register and then reads that register. The acknowledge latches the winning vector and marks that source in service in the same cycle. If no eligible request remains when the acknowledge lands, for example because the source was masked in the meantime, the reserved error vector 0 is latched instead and nothing is marked. Software ends service by writing ones to the in-service register.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0 and reads of addresses 0, 1, 2 and 3 all return 0.
- R2: Address 1 is the mask, one bit per source; bit n = 1 enables source n, and it reads back as written. A source whose mask bit is 0 never raises `irq_o`.
- R3: Configuration bit 0 is the global enable; while it is 0, `irq_o` stays 0 whatever the requests are.
- R4: Requests are level sensitive: `irq_o` falls once the only eligible request is removed.
- R5: With promotion off, the highest-numbered eligible source wins the acknowledge.
- R6: Configuration bit 1 enables promotion and bits 12:8 hold the promoted source; that source then ranks above all others, including for the in-service comparison.
- R7: A write to address 3 with bit 0 = 1 latches the winner; a following read of address 3 returns it in bits 15:11, and the winner's in-service bit is set by the same write.
- R8: A write to address 3 with bit 0 = 0 changes neither the latched vector nor the in-service set.
- R9: Writing address 2 clears each in-service bit written as 1 and leaves bits written as 0 unchanged.
- R10: `irq_o` is raised only if an eligible source ranks above every source in service; sources of equal or lower rank are held off.
- R11: An acknowledge with no eligible source above the in-service set latches vector 0 and leaves the in-service set unchanged.
- R12: Configuration bits 15:13 select the request level; `irq_level_o` presents them, and the whole configuration reads back as written.
- R13: Source 0 is reserved as the error vector; its request never raises `irq_o` and it never enters service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req_i | input | 32 | Level request per source vector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after `reg_rd_i` |
| irq_o | output | 1 | Registered request to the processor |
| irq_level_o | output | 3 | Selected request level |

## Verification
Read data is registered: it is valid one clock after the read strobe. The request line is also registered. It reflects a change on `src_req_i` after one rising edge. A register write needs two edges to show on `irq_o`: one to update the register and one for the line. Acknowledge results are visible to a read issued in the next cycle.

All stimulus is driven on falling edges. Each check waits the stated number of edges and samples on a falling edge, so no check races the edge that updates the value it looks at.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned LVL_W       = 3;
  localparam int unsigned CFG_EN_BIT  = 0;
  localparam int unsigned CFG_PEN_BIT = 1;
  localparam int unsigned CFG_PSRC_LSB = 8;
  localparam int unsigned CFG_LVL_LSB = 13;
  localparam int unsigned VEC_LSB     = 11;
  localparam int unsigned ACK_BIT     = 0;

  typedef enum logic [1:0] {
    RA_CFG  = 2'd0,
    RA_MASK = 2'd1,
    RA_ISR  = 2'd2,
    RA_VEC  = 2'd3
  } pirq_addr_e;
endpackage

// File: rtl/pirq_rank_pick.sv
module pirq_rank_pick #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned VW   = $clog2(NSRC),
  parameter int unsigned RW   = VW + 1
) (
  input  logic [NSRC-1:0] bits_i,
  input  logic            prom_en_i,
  input  logic [VW-1:0]   prom_src_i,
  output logic            found_o,
  output logic [VW-1:0]   idx_o,
  output logic [RW-1:0]   rank_o
);
  logic [RW-1:0] rank_of [NSRC];

  // Rank per source: promoted source sits at NSRC, others at their index.
  for (genvar i = 0; i < NSRC; i++) begin : g_rank
    assign rank_of[i] = (prom_en_i && prom_src_i == VW'(i)) ? RW'(NSRC) : RW'(i);
  end

  // Source 0 is the reserved error vector and never competes.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    rank_o  = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (bits_i[i] && rank_of[i] > rank_o) begin
        found_o = 1'b1;
        idx_o   = VW'(i);
        rank_o  = rank_of[i];
      end
    end
  end
endmodule

// File: rtl/pirq_regbank.sv
module pirq_regbank
  import pirq_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned VW   = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ack_ok_i,
  input  logic [VW-1:0]    ack_vec_i,
  output logic             cfg_en_o,
  output logic             cfg_pen_o,
  output logic [VW-1:0]    cfg_psrc_o,
  output logic [LVL_W-1:0] cfg_lvl_o,
  output logic [NSRC-1:0]  mask_o,
  output logic [NSRC-1:0]  isr_o,
  output logic [VW-1:0]    vec_o,
  output logic [DW-1:0]    rdata_o
);
  logic wr_cfg, wr_mask, wr_isr, ack;
  logic [DW-1:0] cfg_word, vec_word, rd_mux;

  assign wr_cfg  = wr_i && addr_i == RA_CFG;
  assign wr_mask = wr_i && addr_i == RA_MASK;
  assign wr_isr  = wr_i && addr_i == RA_ISR;
  assign ack     = wr_i && addr_i == RA_VEC && wdata_i[ACK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en_o   <= 1'b0;
      cfg_pen_o  <= 1'b0;
      cfg_psrc_o <= '0;
      cfg_lvl_o  <= '0;
    end else if (wr_cfg) begin
      cfg_en_o   <= wdata_i[CFG_EN_BIT];
      cfg_pen_o  <= wdata_i[CFG_PEN_BIT];
      cfg_psrc_o <= wdata_i[CFG_PSRC_LSB +: VW];
      cfg_lvl_o  <= wdata_i[CFG_LVL_LSB +: LVL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_o <= '0;
    else if (wr_mask) mask_o <= wdata_i[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_o <= '0;
      vec_o <= '0;
    end else if (wr_isr) begin
      isr_o <= isr_o & ~wdata_i[NSRC-1:0];
    end else if (ack) begin
      vec_o <= ack_ok_i ? ack_vec_i : '0;
      if (ack_ok_i) isr_o <= isr_o | (NSRC'(1) << ack_vec_i);
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_EN_BIT]                 = cfg_en_o;
    cfg_word[CFG_PEN_BIT]                = cfg_pen_o;
    cfg_word[CFG_PSRC_LSB +: VW]         = cfg_psrc_o;
    cfg_word[CFG_LVL_LSB +: LVL_W]       = cfg_lvl_o;
    vec_word = '0;
    vec_word[VEC_LSB +: VW]              = vec_o;
    unique case (addr_i)
      RA_CFG:  rd_mux = cfg_word;
      RA_MASK: rd_mux = DW'(mask_o);
      RA_ISR:  rd_mux = DW'(isr_o);
      default: rd_mux = vec_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o,
  output logic [LVL_W-1:0] irq_level_o
);
  localparam int unsigned VW = $clog2(NSRC);
  localparam int unsigned RW = VW + 1;

  logic            cfg_en, cfg_pen;
  logic [VW-1:0]   cfg_psrc;
  logic [NSRC-1:0] mask_q, isr_q, eligible;
  logic [VW-1:0]   vec_q, win_idx, isr_idx;
  logic [RW-1:0]   win_rank, isr_rank;
  logic            win_found, isr_found, above;

  pirq_regbank #(.NSRC(NSRC), .VW(VW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .ack_ok_i   (above),
    .ack_vec_i  (win_idx),
    .cfg_en_o   (cfg_en),
    .cfg_pen_o  (cfg_pen),
    .cfg_psrc_o (cfg_psrc),
    .cfg_lvl_o  (irq_level_o),
    .mask_o     (mask_q),
    .isr_o      (isr_q),
    .vec_o      (vec_q),
    .rdata_o    (reg_rdata_o)
  );

  assign eligible = src_req_i & mask_q & ~isr_q;

  pirq_rank_pick #(.NSRC(NSRC), .VW(VW), .RW(RW)) u_win (
    .bits_i     (eligible),
    .prom_en_i  (cfg_pen),
    .prom_src_i (cfg_psrc),
    .found_o    (win_found),
    .idx_o      (win_idx),
    .rank_o     (win_rank)
  );

  pirq_rank_pick #(.NSRC(NSRC), .VW(VW), .RW(RW)) u_svc (
    .bits_i     (isr_q),
    .prom_en_i  (cfg_pen),
    .prom_src_i (cfg_psrc),
    .found_o    (isr_found),
    .idx_o      (isr_idx),
    .rank_o     (isr_rank)
  );

  // An empty in-service set has rank 0, below every real source.
  assign above = win_found && (win_rank > (isr_found ? isr_rank : RW'(0)));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= cfg_en && above;
  end

  logic unused_ok;
  assign unused_ok = ^isr_idx;
endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned VW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_i,
  input logic [1:0]      reg_addr_i,
  input logic [31:0]     reg_wdata_i,
  input logic            irq_o,
  input logic            cfg_en,
  input logic [NSRC-1:0] eligible,
  input logic [NSRC-1:0] isr_q,
  input logic [VW-1:0]   vec_q
);
  p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !irq_o);

  p_none_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible[NSRC-1:1] == '0) |=> !irq_o);

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd2) |=> ((isr_q & $past(reg_wdata_i[NSRC-1:0])) == '0));

  p_err_keeps_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd3 && reg_wdata_i[0]) |=>
      ((vec_q == '0) == (isr_q == $past(isr_q))));

  p_ack_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd3 && reg_wdata_i[0]) |=>
      (vec_q == '0 || $countones(isr_q) == $countones($past(isr_q)) + 1));

  p_src0_never_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_q[0]);
endmodule

bind pirq_ctrl pirq_ctrl_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .cfg_en      (cfg_en),
  .eligible    (eligible),
  .isr_q       (isr_q),
  .vec_q       (vec_q)
);

// File: tb/pirq_ctrl_tb_top.sv
module pirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [2:0]  lvl;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pirq_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req_i   (src_req),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .irq_level_o (lvl)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic ack_read(output logic [31:0] v);
    wreg(2'd3, 32'h1);
    rreg(2'd3, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rreg(2'(a), v);
      chk("R1 reg", v, 32'h0);
    end
  endtask

  task automatic t_mask_enable();
    logic [31:0] v;
    wreg(2'd1, 32'hA5A5_A5A4);
    rreg(2'd1, v);
    chk("R2 readback", v, 32'hA5A5_A5A4);
    src_req = 32'hFFFF_FFFF;
    settle();
    chk("R3 gate off", {31'b0, irq}, 32'h0);
    wreg(2'd1, 32'h0);
    wreg(2'd0, 32'h1);
    settle();
    chk("R2 all masked", {31'b0, irq}, 32'h0);
    wreg(2'd1, 32'h20);
    settle();
    chk("R2 one enabled", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_level_and_src0();
    src_req = 32'h20;
    settle();
    chk("R4 high", {31'b0, irq}, 32'h1);
    src_req = 32'h0;
    @(negedge clk);
    chk("R4 drop", {31'b0, irq}, 32'h0);
    wreg(2'd1, 32'h1);
    src_req = 32'h1;
    settle();
    chk("R13 src0 no irq", {31'b0, irq}, 32'h0);
    src_req = 32'h0;
  endtask

  task automatic t_fixed_prio();
    logic [31:0] v;
    wreg(2'd1, 32'hFFFF_FFFF);
    src_req = (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 17);
    settle();
    ack_read(v);
    chk("R5 R7 vector", v, 32'(17) << 11);
    rreg(2'd2, v);
    chk("R7 in service", v, 32'h1 << 17);
    settle();
    chk("R10 lower held", {31'b0, irq}, 32'h0);
    src_req = src_req | (32'h1 << 25);
    settle();
    chk("R10 higher passes", {31'b0, irq}, 32'h1);
    ack_read(v);
    chk("R5 second vector", v, 32'(25) << 11);
    wreg(2'd2, 32'h0);
    rreg(2'd2, v);
    chk("R9 zero write", v, (32'h1 << 25) | (32'h1 << 17));
    wreg(2'd2, (32'h1 << 25) | (32'h1 << 2));
    rreg(2'd2, v);
    chk("R9 partial clear", v, 32'h1 << 17);
    wreg(2'd2, 32'h1 << 17);
    rreg(2'd2, v);
    chk("R9 cleared", v, 32'h0);
    src_req = '0;
  endtask

  task automatic t_promote_and_ignored();
    logic [31:0] v;
    wreg(2'd0, 32'h3 | (32'd4 << 8));
    src_req = (32'h1 << 4) | (32'h1 << 30);
    settle();
    ack_read(v);
    chk("R6 promoted wins", v, 32'(4) << 11);
    settle();
    chk("R6 R10 promoted in service", {31'b0, irq}, 32'h0);
    wreg(2'd3, 32'h2);
    rreg(2'd3, v);
    chk("R8 vector kept", v, 32'(4) << 11);
    rreg(2'd2, v);
    chk("R8 isr kept", v, 32'h1 << 4);
    wreg(2'd2, 32'hFFFF_FFFF);
    wreg(2'd0, 32'h1);
    src_req = '0;
  endtask

  task automatic t_error_vec();
    logic [31:0] v;
    src_req = 32'h1 << 12;
    settle();
    chk("R11 pending", {31'b0, irq}, 32'h1);
    wreg(2'd1, 32'h0);
    ack_read(v);
    chk("R11 error vector", v, 32'h0);
    rreg(2'd2, v);
    chk("R11 isr untouched", v, 32'h0);
    src_req = '0;
  endtask

  task automatic t_level_field();
    logic [31:0] v;
    wreg(2'd0, (32'd5 << 13) | (32'd7 << 8) | 32'h1);
    rreg(2'd0, v);
    chk("R12 cfg readback", v, (32'd5 << 13) | (32'd7 << 8) | 32'h1);
    chk("R12 level pins", {29'b0, lvl}, 32'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_enable();
    t_level_and_src0();
    t_fixed_prio();
    t_promote_and_ignored();
    t_error_vec();
    t_level_field();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule